// File: doc/BRIEF.md
# Real-time link character multiplexer

This block shares one serial-link character stream between two traffic classes, ahead of an 8b/10b encoder. Real-time (RT) packets travel as plain data characters. A low-rate byte stream for housekeeping traffic travels only as K28.y special characters. Because the character space alone tells the two classes apart, the receive side can sort each character with no history, and the link never pushes back on RT traffic. A non-RT character is only ever sent in the idle slots that separate RT packets.

The datapath carries LANES characters per cycle (four by default: a 32-bit word at 125 MHz for a 5 Gb/s line). Lane 0 sits in bits [7:0] and goes on the line first. The RT source marks each lane valid or idle, and every idle lane becomes a gap slot. Each non-RT byte takes four gap slots: a start marker, then three payload characters that carry three, three and two bits of the byte in the y field. Gap slots with nothing to send carry a filler character. The receive half takes the line characters back, sends data characters to the RT output with a start-of-packet flag, and rebuilds the non-RT bytes.

Top module: `rtlink_mux`

## Requirements
- R1: A valid RT lane appears on the same tx lane one cycle later as a data character (tx_k_o bit 0) holding the input byte unchanged.
- R2: An idle RT lane appears one cycle later as a K character (tx_k_o bit 1) of the form {y, 5'b11100}.
- R3: RT input has no ready signal and is taken every cycle. Non-RT activity never changes, delays or drops an RT character.
- R4: An accepted non-RT byte b is sent in the next four gap slots, in lane order and across cycles, as K28.1 (0x3C), then y=b[2:0], y=b[5:3], y={0,b[7:6]}. The first of these slots is in the cycle after acceptance.
- R5: A gap slot with no pending non-RT symbol carries the filler K28.5 (0xBC).
- R6: nrt_ready_o is high only when no byte is in progress. It is low in the cycle after an acceptance and rises again after the cycle that used the last payload slot.
- R7: One cycle after a line character arrives, rx_rt_vld_o is set for data characters, with the byte on rx_rt_data_o. It is clear for K characters.
- R8: rx_rt_sop_o is set on a data character whose preceding line character (earlier lane, or lane LANES-1 of the previous cycle) was a K character. The first data character after reset counts as a start.
- R9: The receiver rebuilds each non-RT byte from a K28.1 marker and the next three K characters. It pulses rx_nrt_valid_o for one cycle with the byte, in the cycle after the last chunk arrives. Outside a byte, K characters other than K28.1 are ignored.
- R10: RT packets of length 1 to MAX_PKT (256) with at least one idle lane between packets pass end to end unchanged.
- R11: During reset every tx lane holds 0xBC with tx_k_o all ones, nrt_ready_o is high, and both receive valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rt_data_i | input | 8*LANES | RT characters, lane 0 in the low byte |
| rt_vld_i | input | LANES | Per-lane RT valid; clear marks a gap slot |
| nrt_byte_i | input | 8 | Non-RT byte |
| nrt_valid_i | input | 1 | Non-RT byte offered |
| nrt_ready_o | output | 1 | Non-RT byte accepted when high with valid |
| tx_char_o | output | 8*LANES | Line characters to the encoder |
| tx_k_o | output | LANES | Per-lane special-character flag |
| rx_char_i | input | 8*LANES | Line characters from the decoder |
| rx_k_i | input | LANES | Per-lane special-character flag from the decoder |
| rx_rt_data_o | output | 8*LANES | Received RT characters |
| rx_rt_vld_o | output | LANES | Per-lane RT valid |
| rx_rt_sop_o | output | LANES | Per-lane RT start of packet |
| rx_nrt_byte_o | output | 8 | Rebuilt non-RT byte |
| rx_nrt_valid_o | output | 1 | Rebuilt byte valid pulse |

## Verification
The tx characters depend on inputs sampled one edge earlier. The bench therefore stores each driven cycle and compares it at the next clock, a quarter period after the edge. Non-RT symbols for a byte accepted at edge t first appear in the output registered at edge t+1. The expected-symbol queue is released only after the check for edge t has run. With tx looped back into rx, the receive outputs trail the tx outputs by one more cycle, and they are popped from the RT and byte queues in lane order. The ready drop for R6 is sampled one cycle after each acceptance.

// File: rtl/rtlink_pkg.sv
package rtlink_pkg;
  localparam int CW = 8;
  localparam logic [4:0] K28_LO = 5'b11100;
  localparam logic [2:0] Y_MARK = 3'd1;
  localparam logic [2:0] Y_FILL = 3'd5;

  function automatic logic [CW-1:0] k28(input logic [2:0] y);
    return {y, K28_LO};
  endfunction
endpackage

// File: rtl/rtlink_nrt_ser.sv
module rtlink_nrt_ser
  import rtlink_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LANES-1:0]   gap_i,
  input  logic [7:0]         byte_i,
  input  logic               valid_i,
  output logic               ready_o,
  output logic [LANES*CW-1:0] sym_o
);
  localparam int PW = $clog2(LANES + 4) + 1;

  logic          busy_q;
  logic [PW-1:0] phase_q;
  logic [7:0]    byte_q;
  logic [PW-1:0] gap_cnt;
  logic [LANES-1:0] mark_v;

  assign ready_o = !busy_q;

  // gap lanes take successive symbol positions in lane order
  always_comb begin
    logic [PW-1:0] pos;
    pos     = '0;
    gap_cnt = '0;
    mark_v  = '0;
    sym_o   = {LANES{k28(Y_FILL)}};
    for (int l = 0; l < LANES; l++) begin
      if (gap_i[l]) begin
        pos = phase_q + gap_cnt;
        if (busy_q && pos < PW'(4)) begin
          case (pos[1:0])
            2'd0: begin
              sym_o[l*CW +: CW] = k28(Y_MARK);
              mark_v[l] = 1'b1;
            end
            2'd1: sym_o[l*CW +: CW] = k28(byte_q[2:0]);
            2'd2: sym_o[l*CW +: CW] = k28(byte_q[5:3]);
            default: sym_o[l*CW +: CW] = k28({1'b0, byte_q[7:6]});
          endcase
        end
        gap_cnt = gap_cnt + PW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= '0;
      byte_q  <= '0;
    end else if (!busy_q) begin
      if (valid_i) begin
        busy_q  <= 1'b1;
        phase_q <= '0;
        byte_q  <= byte_i;
      end
    end else if (phase_q + gap_cnt >= PW'(4)) begin
      busy_q <= 1'b0;
    end else begin
      phase_q <= phase_q + gap_cnt;
    end
  end

  AST_READY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> !ready_o); // R6
  AST_ONE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mark_v) <= 1); // R4
endmodule

// File: rtl/rtlink_tx.sv
module rtlink_tx
  import rtlink_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int MAX_PKT = 256
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [LANES*CW-1:0] rt_data_i,
  input  logic [LANES-1:0]    rt_vld_i,
  input  logic [7:0]          nrt_byte_i,
  input  logic                nrt_valid_i,
  output logic                nrt_ready_o,
  output logic [LANES*CW-1:0] tx_char_o,
  output logic [LANES-1:0]    tx_k_o
);
  localparam int RW = $clog2(MAX_PKT + 2) + 1;

  logic [LANES-1:0]    gap;
  logic [LANES*CW-1:0] sym;
  logic [LANES*CW-1:0] char_d;

  assign gap = ~rt_vld_i;

  rtlink_nrt_ser #(.LANES(LANES)) u_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gap_i  (gap),
    .byte_i (nrt_byte_i),
    .valid_i(nrt_valid_i),
    .ready_o(nrt_ready_o),
    .sym_o  (sym)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign char_d[l*CW +: CW] = rt_vld_i[l] ? rt_data_i[l*CW +: CW] : sym[l*CW +: CW];

    AST_D_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) && !tx_k_o[l] |-> tx_char_o[l*CW +: CW] == $past(rt_data_i[l*CW +: CW])); // R1
    AST_K_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_k_o[l] |-> tx_char_o[l*CW +: 5] == K28_LO); // R2
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_char_o <= {LANES{k28(Y_FILL)}};
      tx_k_o    <= '1;
    end else begin
      tx_char_o <= char_d;
      tx_k_o    <= gap;
    end
  end

  // packet length watch for the source contract
  logic [RW-1:0] run_q, run_d, run_max;
  always_comb begin
    run_d   = run_q;
    run_max = '0;
    for (int l = 0; l < LANES; l++) begin
      if (rt_vld_i[l]) begin
        if (run_d != {RW{1'b1}}) run_d = run_d + RW'(1);
        if (run_d > run_max) run_max = run_d;
      end else begin
        run_d = '0;
      end
    end
  end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else         run_q <= run_d;
  end

  AST_PKT_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_max <= RW'(MAX_PKT)); // R10
  AST_K_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> tx_k_o == ~$past(rt_vld_i)); // R2
endmodule

// File: rtl/rtlink_rx.sv
module rtlink_rx
  import rtlink_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [LANES*CW-1:0] rx_char_i,
  input  logic [LANES-1:0]    rx_k_i,
  output logic [LANES*CW-1:0] rt_data_o,
  output logic [LANES-1:0]    rt_vld_o,
  output logic [LANES-1:0]    rt_sop_o,
  output logic [7:0]          nrt_byte_o,
  output logic                nrt_valid_o
);
  logic       prev_k_q, prev_k_d;
  logic       in_q, in_d;
  logic [1:0] idx_q, idx_d;
  logic [7:0] acc_q, acc_d;
  logic [LANES-1:0] sop_d;
  logic       done_d;
  logic [7:0] byte_d;

  always_comb begin
    logic [CW-1:0] c;
    prev_k_d = prev_k_q;
    in_d     = in_q;
    idx_d    = idx_q;
    acc_d    = acc_q;
    sop_d    = '0;
    done_d   = 1'b0;
    byte_d   = '0;
    for (int l = 0; l < LANES; l++) begin
      c = rx_char_i[l*CW +: CW];
      if (rx_k_i[l]) begin
        if (in_d) begin
          case (idx_d)
            2'd0: acc_d[2:0] = c[7:5];
            2'd1: acc_d[5:3] = c[7:5];
            default: begin
              acc_d[7:6] = c[6:5];
              byte_d     = acc_d;
              done_d     = 1'b1;
              in_d       = 1'b0;
            end
          endcase
          idx_d = (idx_d == 2'd2) ? 2'd0 : idx_d + 2'd1;
        end else if (c == k28(Y_MARK)) begin
          in_d  = 1'b1;
          idx_d = 2'd0;
        end
      end else begin
        sop_d[l] = prev_k_d;
      end
      prev_k_d = rx_k_i[l];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_k_q    <= 1'b1;
      in_q        <= 1'b0;
      idx_q       <= '0;
      acc_q       <= '0;
      rt_data_o   <= '0;
      rt_vld_o    <= '0;
      rt_sop_o    <= '0;
      nrt_byte_o  <= '0;
      nrt_valid_o <= 1'b0;
    end else begin
      prev_k_q    <= prev_k_d;
      in_q        <= in_d;
      idx_q       <= idx_d;
      acc_q       <= acc_d;
      rt_data_o   <= rx_char_i;
      rt_vld_o    <= ~rx_k_i;
      rt_sop_o    <= sop_d;
      nrt_valid_o <= done_d;
      if (done_d) nrt_byte_o <= byte_d;
    end
  end

  AST_RT_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> rt_vld_o == ~$past(rx_k_i)); // R7
  for (genvar l = 1; l < LANES; l++) begin : g_sop
    AST_SOP_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rt_sop_o[l] |-> rt_vld_o[l] && !rt_vld_o[l-1]); // R8
  end
  AST_NRT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !nrt_valid_o |-> $stable(nrt_byte_o)); // R9
endmodule

// File: rtl/rtlink_mux.sv
module rtlink_mux
  import rtlink_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int MAX_PKT = 256
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [LANES*8-1:0]  rt_data_i,
  input  logic [LANES-1:0]    rt_vld_i,
  input  logic [7:0]          nrt_byte_i,
  input  logic                nrt_valid_i,
  output logic                nrt_ready_o,
  output logic [LANES*8-1:0]  tx_char_o,
  output logic [LANES-1:0]    tx_k_o,
  input  logic [LANES*8-1:0]  rx_char_i,
  input  logic [LANES-1:0]    rx_k_i,
  output logic [LANES*8-1:0]  rx_rt_data_o,
  output logic [LANES-1:0]    rx_rt_vld_o,
  output logic [LANES-1:0]    rx_rt_sop_o,
  output logic [7:0]          rx_nrt_byte_o,
  output logic                rx_nrt_valid_o
);
  rtlink_tx #(.LANES(LANES), .MAX_PKT(MAX_PKT)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rt_data_i  (rt_data_i),
    .rt_vld_i   (rt_vld_i),
    .nrt_byte_i (nrt_byte_i),
    .nrt_valid_i(nrt_valid_i),
    .nrt_ready_o(nrt_ready_o),
    .tx_char_o  (tx_char_o),
    .tx_k_o     (tx_k_o)
  );

  rtlink_rx #(.LANES(LANES)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_char_i  (rx_char_i),
    .rx_k_i     (rx_k_i),
    .rt_data_o  (rx_rt_data_o),
    .rt_vld_o   (rx_rt_vld_o),
    .rt_sop_o   (rx_rt_sop_o),
    .nrt_byte_o (rx_nrt_byte_o),
    .nrt_valid_o(rx_nrt_valid_o)
  );
endmodule

// File: tb/rtlink_mux_bench.sv
module rtlink_mux_bench;
  localparam int LANES = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [LANES*8-1:0] rt_data = '0;
  logic [LANES-1:0]   rt_vld = '0;
  logic [7:0]         nrt_byte = '0;
  logic               nrt_valid = 1'b0;
  logic               nrt_ready;
  logic [LANES*8-1:0] tx_char, rx_data;
  logic [LANES-1:0]   tx_k, rx_vld, rx_sop;
  logic [7:0]         rx_byte;
  logic               rx_bvalid;

  always #10 clk = ~clk;

  rtlink_mux u_rtlink_mux (
    .clk_i(clk), .rst_ni(rst_ni),
    .rt_data_i(rt_data), .rt_vld_i(rt_vld),
    .nrt_byte_i(nrt_byte), .nrt_valid_i(nrt_valid), .nrt_ready_o(nrt_ready),
    .tx_char_o(tx_char), .tx_k_o(tx_k),
    .rx_char_i(tx_char), .rx_k_i(tx_k),
    .rx_rt_data_o(rx_data), .rx_rt_vld_o(rx_vld), .rx_rt_sop_o(rx_sop),
    .rx_nrt_byte_o(rx_byte), .rx_nrt_valid_o(rx_bvalid)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] q_txd[$];
  logic [3:0]  q_txv[$];
  logic [7:0]  q_stage[$], q_sym[$];
  logic [8:0]  q_rt[$];
  logic [7:0]  q_nrt[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // tx monitor: output of edge P reflects inputs driven before P
  always begin
    @(posedge clk); #5;
    if (rst_ni && q_txv.size() > 0) begin
      logic [31:0] d; logic [3:0] v; logic [7:0] e;
      d = q_txd.pop_front(); v = q_txv.pop_front();
      for (int l = 0; l < LANES; l++) begin
        if (v[l]) begin
          chk(!tx_k[l] && tx_char[l*8+:8] == d[l*8+:8], "R1/R3", "rt lane",
              {tx_k[l], tx_char[l*8+:8]}, {1'b0, d[l*8+:8]});
        end else begin
          e = (q_sym.size() > 0) ? q_sym.pop_front() : 8'hBC;
          chk(tx_k[l] && tx_char[l*8+:8] == e, (e == 8'hBC) ? "R2/R5" : "R2/R4",
              "gap lane", {tx_k[l], tx_char[l*8+:8]}, {1'b1, e});
        end
      end
    end
    while (q_stage.size() > 0) q_sym.push_back(q_stage.pop_front());
  end

  // rx monitor
  always begin
    @(posedge clk); #5;
    if (rst_ni) begin
      for (int l = 0; l < LANES; l++) begin
        if (rx_vld[l]) begin
          if (q_rt.size() == 0) chk(1'b0, "R7", "unexpected rt char", rx_data[l*8+:8], 0);
          else begin
            logic [8:0] e;
            e = q_rt.pop_front();
            chk({rx_sop[l], rx_data[l*8+:8]} == e, "R7/R8/R10", "rx rt",
                {rx_sop[l], rx_data[l*8+:8]}, e);
          end
        end
      end
      if (rx_bvalid) begin
        if (q_nrt.size() == 0) chk(1'b0, "R9", "unexpected byte", rx_byte, 0);
        else begin
          logic [7:0] e;
          e = q_nrt.pop_front();
          chk(rx_byte == e, "R9", "rx byte", rx_byte, e);
        end
      end
    end
  end

  int pkt_rem = 0, gap_rem = 2, pkts_left = 40, pkt_idx = 0;
  bit first = 1'b0, have = 1'b0, acc_prev = 1'b0;
  int nrt_rate = 40;

  function automatic int next_len(input int idx);
    case (idx)
      0: return 256;
      1: return 1;
      2: return 256;
      3: return 2;
      default: return $urandom_range(1, 256);
    endcase
  endfunction

  task automatic drive_cycle(input bit allow_rt);
    logic [31:0] d; logic [3:0] v;
    d = '0; v = '0;
    for (int l = 0; l < LANES; l++) begin
      if (pkt_rem > 0) begin
        v[l] = 1'b1;
        d[l*8+:8] = 8'($urandom);
        q_rt.push_back({first, d[l*8+:8]});
        first = 1'b0;
        pkt_rem--;
        if (pkt_rem == 0) gap_rem = $urandom_range(1, 3);
      end else begin
        if (gap_rem > 0) gap_rem--;
        if (gap_rem == 0 && pkts_left > 0 && allow_rt) begin
          pkt_rem = next_len(pkt_idx);
          pkt_idx++;
          pkts_left--;
          first = 1'b1;
        end
      end
    end
    rt_data = d; rt_vld = v;
    q_txd.push_back(d); q_txv.push_back(v);
    // non-RT driver
    if (acc_prev) begin
      chk(!nrt_ready, "R6", "ready after accept", nrt_ready, 0);
      have = 1'b0;
    end
    if (!have && nrt_rate > 0 && $urandom_range(0, 99) < nrt_rate) begin
      have = 1'b1;
      nrt_byte = 8'($urandom);
    end
    nrt_valid = have;
    acc_prev = have && nrt_ready;
    if (acc_prev) begin
      q_stage.push_back(8'h3C);
      q_stage.push_back({nrt_byte[2:0], 5'h1C});
      q_stage.push_back({nrt_byte[5:3], 5'h1C});
      q_stage.push_back({1'b0, nrt_byte[7:6], 5'h1C});
      q_nrt.push_back(nrt_byte);
    end
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    chk(tx_char == {4{8'hBC}}, "R11", "reset tx_char", tx_char, {4{8'hBC}});
    chk(tx_k == 4'hF, "R11", "reset tx_k", tx_k, 4'hF);
    chk(nrt_ready == 1'b1, "R11", "reset ready", nrt_ready, 1);
    chk(rx_vld == 4'h0 && !rx_bvalid, "R11", "reset rx valid", {rx_vld, rx_bvalid}, 0);
    rst_ni = 1'b1;
    // mixed traffic, including 256 and 1 character packets (R10)
    while ((pkts_left > 0 || pkt_rem > 0) && n_chk < 100000) begin
      @(negedge clk);
      drive_cycle(1'b1);
    end
    // all-gap phase: four gap slots per cycle, bytes back to back (R4)
    nrt_rate = 100;
    repeat (200) begin
      @(negedge clk);
      drive_cycle(1'b0);
    end
    nrt_rate = 0;
    repeat (20) begin
      @(negedge clk);
      drive_cycle(1'b0);
    end
    @(negedge clk);
    chk(q_rt.size() == 0, "R10", "rt queue drained", q_rt.size(), 0);
    chk(q_nrt.size() == 0, "R9", "byte queue drained", q_nrt.size(), 0);
    chk(q_sym.size() == 0 && q_stage.size() == 0, "R4", "symbol queue drained",
        q_sym.size(), 0);
    chk(nrt_ready, "R6", "ready when idle", nrt_ready, 1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule